// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block sits between a simple synchronous request port and the pins of a 256K x 16 extended-data-out DRAM. A client presents an 18-bit word address, write data, two byte enables and a read/write flag with a valid/ready handshake. The controller turns each request into RAS, CAS, WE and OE strobe sequences on a shared 9-bit row/column address bus, and returns read data with a single-cycle valid pulse.

After an access the row is left open. A following request to the same row is served in page mode: only the column is presented and only the CAS lines toggle. A request to a different row closes the open row with a RAS precharge first. A built-in interval timer requests CAS-before-RAS refresh often enough to cover every row in the refresh period. A guard counter closes any open row before RAS could stay low longer than allowed. All strobe timings are parameters counted in clock cycles.

Top module: `edo_ctrl`

## Requirements
- R1: The word address is split with bits 17..9 as the row and bits 8..0 as the column. The row is on `dram_addr` when RAS falls and the column is on `dram_addr` when CAS falls.
- R2: `req_be[0]` selects the lower CAS line `dram_cas_n[0]` and `req_be[1]` selects the upper line `dram_cas_n[1]`. A request with both enables clear is carried out as a full-word access, so every access lowers at least one CAS line.
- R3: A write is an early write. WE is already low in the cycle before CAS falls and stays low while CAS is low. OE stays high, and the write data is driven on `dram_dq_out` for the enabled lanes.
- R4: A read holds WE high and OE low while CAS is low. It returns the enabled lanes of the stored word on `rsp_rdata` together with a one-cycle `rsp_valid` pulse, exactly one pulse per read, in request order.
- R5: A request to the row that is already open causes no new RAS fall. Only the column is presented and CAS toggles.
- R6: Every RAS fall is preceded by at least `T_RP` cycles with RAS high. A request to a different row therefore closes the open row first.
- R7: Refresh lowers both CAS lines while RAS is high and WE is high, then lowers RAS. The data bus is not driven during refresh.
- R8: Refresh sequences start no more than `REF_CYCLES` plus a bounded access latency apart. By default `REF_CYCLES` is derived from the clock frequency for a 15.6 us interval.
- R9: A pending refresh is served before any new request. If a row is open, RAS is first raised and held high for at least `T_RP` cycles before the refresh CAS falls.
- R10: RAS never stays low for more than `T_RAS_MAX` consecutive cycles. An open, idle row is closed on its own.
- R11: `dram_dq_oe` is high only while a write cycle holds RAS low and WE low. In standby the bus is released.
- R12: After reset all strobes are high, the bus is released, `rsp_valid` is low and `req_ready` is high. `req_ready` is low whenever any CAS line is low.
- R13: CAS falls no earlier than `T_RCD` cycles after RAS falls and stays low for exactly `T_CAS` cycles. Between page-mode CAS pulses, CAS is high for at least `T_CP` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address (row in the upper 9 bits) |
| req_be | input | 2 | Byte enables, bit 0 = lower byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes, bit 0 lower byte, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 16 | Data returned from the DRAM |

## Verification
The hardest situations to reach from the ports are the collisions: a refresh timer tick that lands while a row is open in the middle of page traffic, and the RAS-low guard firing on an idle open row. The bench synchronises to an observed refresh and then issues a same-row burst, so the page-hit pattern is known in advance. It then leaves a row open with no traffic well past `T_RAS_MAX`. Long stretches of mixed traffic over a few rows, with random byte enables, make refresh ticks fall on every phase of the access sequence. A behavioural DRAM model in the bench checks every strobe edge against a queue of accepted requests.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_RCD  = 4'd1,
        ST_PSET = 4'd2,
        ST_CAS  = 4'd3,
        ST_CP   = 4'd4,
        ST_OPEN = 4'd5,
        ST_PRE  = 4'd6,
        ST_RCAS = 4'd7,
        ST_RRAS = 4'd8
    } edo_state_e;

    function automatic logic ras_is_low(input edo_state_e s);
        return (s == ST_RCD) || (s == ST_PSET) || (s == ST_CAS) ||
               (s == ST_CP) || (s == ST_OPEN) || (s == ST_RRAS);
    endfunction

    function automatic logic write_phase(input edo_state_e s);
        return (s == ST_RCD) || (s == ST_PSET) || (s == ST_CAS);
    endfunction

endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == '0);

    always_comb begin
        cnt_d = tick ? TW'(INTERVAL - 1) : cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= TW'(INTERVAL - 1);
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
    parameter int LIMIT = 1000,
    parameter int GUARD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic near_limit
);
    localparam int GW        = $clog2(LIMIT + 1) + 1;
    localparam int THRESHOLD = LIMIT - GUARD;

    logic [GW-1:0] run_d, run_q;

    assign near_limit = (run_q >= GW'(THRESHOLD));

    always_comb begin
        if (!ras_low)              run_d = '0;
        else if (run_q != '1)      run_d = run_q + 1'b1;
        else                       run_d = run_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W      = 9,
    parameter int COL_W      = 9,
    parameter int DATA_W     = 16,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 2,
    parameter int T_CP       = 1,
    parameter int T_RP       = 3,
    parameter int T_CSR      = 1,
    parameter int T_REFW     = 3,
    parameter int T_RAS_MAX  = 1000,
    parameter int CLK_KHZ    = 100000,
    parameter int REF_CYCLES = CLK_KHZ * 156 / 10000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W/8-1:0]    req_be,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   dram_ras_n,
    output logic [DATA_W/8-1:0]    dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [ROW_W-1:0]       dram_addr,
    output logic [DATA_W-1:0]      dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_in
);
    localparam int LANES = DATA_W / 8;
    localparam int AW    = ROW_W + COL_W;
    localparam int CW    = $clog2(T_RCD + T_CAS + T_CP + T_RP + T_CSR + T_REFW + 1);

    typedef struct packed {
        edo_state_e        st;
        logic [CW-1:0]     cnt;
        logic              open;
        logic              held;
        logic              ref_pend;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic [LANES-1:0]  lanes;
        logic [DATA_W-1:0] wdata;
        logic              rsp;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t q, d;

    logic             ref_tick;
    logic             near_limit;
    logic             ras_low;
    logic             take;
    logic [LANES-1:0] be_eff;
    logic [ROW_W-1:0] a_row;
    logic [COL_W-1:0] a_col;

    assign a_row   = req_addr[AW-1:COL_W];
    assign a_col   = req_addr[COL_W-1:0];
    assign be_eff  = (req_be == '0) ? '1 : req_be;
    assign ras_low = ras_is_low(q.st);

    edo_ref_timer #(.INTERVAL(REF_CYCLES)) u_ref (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ref_tick)
    );

    edo_ras_guard #(.LIMIT(T_RAS_MAX), .GUARD(T_CAS + T_CP + 3)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_low   (ras_low),
        .near_limit(near_limit)
    );

    assign req_ready = !q.ref_pend &&
                       ((q.st == ST_IDLE) || ((q.st == ST_OPEN) && !near_limit));
    assign take = req_valid && req_ready;

    always_comb begin
        d          = q;
        d.rsp      = 1'b0;
        d.ref_pend = q.ref_pend | ref_tick;
        if (take) begin
            d.col   = a_col;
            d.wr    = req_write;
            d.lanes = be_eff;
            d.wdata = req_wdata;
        end
        case (q.st)
            ST_IDLE: begin
                if (q.ref_pend) begin
                    d.st       = ST_RCAS;
                    d.cnt      = CW'(T_CSR - 1);
                    d.ref_pend = ref_tick;
                end else if (take) begin
                    d.st   = ST_RCD;
                    d.cnt  = CW'(T_RCD - 1);
                    d.open = 1'b1;
                    d.row  = a_row;
                end
            end
            ST_RCD: begin
                if (q.cnt == '0) begin
                    d.st  = ST_CAS;
                    d.cnt = CW'(T_CAS - 1);
                end else d.cnt = q.cnt - 1'b1;
            end
            ST_PSET: begin
                d.st  = ST_CAS;
                d.cnt = CW'(T_CAS - 1);
            end
            ST_CAS: begin
                if (q.cnt == '0) begin
                    if (!q.wr) begin
                        d.rsp   = 1'b1;
                        d.rdata = dram_dq_in;
                    end
                    d.st  = ST_CP;
                    d.cnt = CW'(T_CP - 1);
                end else d.cnt = q.cnt - 1'b1;
            end
            ST_CP: begin
                if (q.cnt == '0) d.st = ST_OPEN;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_OPEN: begin
                if (q.ref_pend || near_limit) begin
                    d.st   = ST_PRE;
                    d.cnt  = CW'(T_RP - 1);
                    d.open = 1'b0;
                    d.held = 1'b0;
                end else if (take) begin
                    if (a_row == q.row) begin
                        d.st = ST_PSET;
                    end else begin
                        d.st   = ST_PRE;
                        d.cnt  = CW'(T_RP - 1);
                        d.open = 1'b0;
                        d.held = 1'b1;
                        d.row  = a_row;
                    end
                end
            end
            ST_PRE: begin
                if (q.cnt == '0) begin
                    if (q.held) begin
                        d.st   = ST_RCD;
                        d.cnt  = CW'(T_RCD - 1);
                        d.open = 1'b1;
                        d.held = 1'b0;
                    end else d.st = ST_IDLE;
                end else d.cnt = q.cnt - 1'b1;
            end
            ST_RCAS: begin
                if (q.cnt == '0) begin
                    d.st  = ST_RRAS;
                    d.cnt = CW'(T_REFW - 1);
                end else d.cnt = q.cnt - 1'b1;
            end
            ST_RRAS: begin
                if (q.cnt == '0) begin
                    d.st   = ST_PRE;
                    d.cnt  = CW'(T_RP - 1);
                    d.held = 1'b0;
                end else d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dram_cas_n[i] = !(((q.st == ST_CAS) && q.lanes[i]) ||
                                 (q.st == ST_RCAS) || (q.st == ST_RRAS));
    end

    assign dram_ras_n  = !ras_low;
    assign dram_we_n   = !(q.wr && write_phase(q.st));
    assign dram_oe_n   = !(!q.wr && (q.st == ST_CAS));
    assign dram_dq_oe  = q.wr && write_phase(q.st);
    assign dram_dq_out = q.wdata;
    assign rsp_valid   = q.rsp;
    assign rsp_rdata   = q.rdata;

    always_comb begin
        case (q.st)
            ST_RCD:                    dram_addr = q.row;
            ST_PSET, ST_CAS, ST_CP:    dram_addr = ROW_W'(q.col);
            default:                   dram_addr = '0;
        endcase
    end
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
    parameter int T_RP      = 3,
    parameter int T_RAS_MAX = 1000,
    parameter int LANES     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             dram_ras_n,
    input logic [LANES-1:0] dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_oe_n,
    input logic             dram_dq_oe
);
    localparam int RW = $clog2(T_RAS_MAX + T_RP + 2) + 1;

    logic          cas_any;
    logic [RW-1:0] low_run_q, high_run_q;

    assign cas_any = !(&dram_cas_n);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            high_run_q <= RW'(T_RP);
        end else begin
            low_run_q  <= dram_ras_n ? '0 : ((low_run_q == '1) ? low_run_q : low_run_q + 1'b1);
            high_run_q <= !dram_ras_n ? '0 : ((high_run_q == '1) ? high_run_q : high_run_q + 1'b1);
        end
    end

    p_dq_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && !dram_ras_n));

    p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n && cas_any) |-> (dram_we_n && !dram_dq_oe));

    p_early_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_any && !$past(cas_any) && !dram_we_n) |-> !$past(dram_we_n));

    p_read_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (dram_we_n && cas_any && !dram_ras_n));

    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cas_any |-> !req_ready);

    p_ras_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (low_run_q < RW'(T_RAS_MAX)));

    p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (high_run_q >= RW'(T_RP)));
endmodule

bind edo_ctrl edo_ctrl_chk #(
    .T_RP     (T_RP),
    .T_RAS_MAX(T_RAS_MAX),
    .LANES    (DATA_W / 8)
) u_chk (.*);

// File: tb/sim_edo_ctrl.sv
module sim_edo_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3, T_CSR = 1, T_REFW = 3;
    localparam int T_RAS_MAX  = 40;
    localparam int REF_CYCLES = 300;
    localparam int SLACK = 2 * (T_RCD + T_CAS + T_CP + T_RP + T_CSR + T_REFW) + 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic req_ready, rsp_valid, dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] rsp_rdata, dram_dq_out;
    logic [15:0] dram_dq_in = '0;
    logic [1:0]  dram_cas_n;
    logic [8:0]  dram_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    edo_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR),
               .T_REFW(T_REFW), .T_RAS_MAX(T_RAS_MAX), .REF_CYCLES(REF_CYCLES)) u0 (.*);

    typedef struct { int addr; bit wr; logic [1:0] lanes; logic [15:0] data; } op_t;
    typedef struct { logic [15:0] mask; logic [15:0] data; } rd_t;
    op_t opq[$];
    rd_t rdq[$];
    bit  hit_log[$];
    logic [15:0] shadow [int];
    logic [15:0] dmem   [int];

    int n_chk = 0, n_err = 0, cyc = 0, ref_cnt = 0, last_ref = 0;
    int ras_low_run = 0, ras_high_run = 100, cas_low_run = 0, cas_high_run = 100;
    bit prev_ras = 1'b1, prev_cas = 1'b0, prev_rsp = 1'b0, ras_fell = 1'b0;
    bit in_acc = 1'b0, acc_wr = 1'b0, done = 1'b0, mon_on = 1'b0;
    int cur_row = 0, cur_col = 0;
    logic [1:0] acc_lanes = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] lmask(input logic [1:0] l);
        return {{8{l[1]}}, {8{l[0]}}};
    endfunction

    function automatic logic [15:0] rd_word(ref logic [15:0] m [int], input int k);
        return m.exists(k) ? m[k] : 16'h0000;
    endfunction

    // behavioural DRAM plus protocol monitor, sampled away from the clock edge
    always @(negedge clk) begin
        if (mon_on) begin
            bit cas_any;
            op_t op;
            rd_t rd;
            cyc++;
            cas_any = !(&dram_cas_n);
            if (prev_ras && !dram_ras_n) begin
                if (cas_any) begin
                    chk(prev_cas, "R7 cas before ras", prev_cas, 1);
                    chk(dram_we_n, "R7 we high in refresh", dram_we_n, 1);
                    chk(ras_high_run >= T_RP, "R9 precharge before refresh", ras_high_run, T_RP);
                    chk(cyc - last_ref <= REF_CYCLES + SLACK, "R8 refresh gap", cyc - last_ref, REF_CYCLES + SLACK);
                    ref_cnt++;
                    last_ref = cyc;
                end else begin
                    cur_row  = int'(dram_addr);
                    ras_fell = 1'b1;
                    chk(ras_high_run >= T_RP, "R6 ras precharge", ras_high_run, T_RP);
                end
            end
            if (dram_ras_n && cas_any)
                chk(!dram_dq_oe, "R7 bus released in refresh", dram_dq_oe, 0);
            if (!dram_ras_n && cas_any && !prev_cas) begin
                if (opq.size() == 0) chk(0, "R1 unexpected access", 1, 0);
                else begin
                    op = opq.pop_front();
                    chk(cur_row == (op.addr >> 9), "R1 row address", cur_row, op.addr >> 9);
                    chk(int'(dram_addr) == (op.addr & 511), "R1 column address", dram_addr, op.addr & 511);
                    chk(~dram_cas_n == op.lanes, "R2 cas lanes", ~dram_cas_n, op.lanes);
                    chk(dram_we_n == !op.wr, "R3 we level", dram_we_n, !op.wr);
                    if (ras_fell) chk(ras_low_run >= T_RCD, "R13 ras to cas", ras_low_run, T_RCD);
                    else          chk(cas_high_run >= T_CP, "R13 cas precharge", cas_high_run, T_CP);
                    hit_log.push_back(!ras_fell);
                    ras_fell  = 1'b0;
                    cur_col   = int'(dram_addr);
                    in_acc    = 1'b1;
                    acc_wr    = op.wr;
                    acc_lanes = op.lanes;
                    if (op.wr) begin
                        logic [15:0] m, w;
                        m = lmask(op.lanes);
                        chk(dram_dq_oe && dram_oe_n, "R3 drive with oe high", {dram_dq_oe, dram_oe_n}, 2'b11);
                        chk((dram_dq_out & m) == (op.data & m), "R3 write data", dram_dq_out & m, op.data & m);
                        w = rd_word(dmem, (cur_row << 9) | cur_col);
                        dmem[(cur_row << 9) | cur_col] = (w & ~m) | (dram_dq_out & m);
                    end
                end
            end
            if (in_acc && cas_any && !acc_wr) begin
                chk(!dram_oe_n && dram_we_n, "R4 read strobes", {dram_oe_n, dram_we_n}, 2'b01);
                dram_dq_in = rd_word(dmem, (cur_row << 9) | cur_col) & lmask(acc_lanes);
            end
            if (in_acc && !cas_any && prev_cas) begin
                chk(cas_low_run == T_CAS, "R13 cas width", cas_low_run, T_CAS);
                in_acc = 1'b0;
            end
            if (dram_dq_oe) chk(!dram_we_n && !dram_ras_n, "R11 drive only in write", {dram_we_n, dram_ras_n}, 0);
            if (dram_ras_n) chk(!dram_dq_oe, "R11 standby released", dram_dq_oe, 0);
            if (cas_any) chk(!req_ready, "R12 busy not ready", req_ready, 0);
            if (!dram_ras_n) chk(ras_low_run + 1 <= T_RAS_MAX, "R10 ras low time", ras_low_run + 1, T_RAS_MAX);
            if (rsp_valid) begin
                chk(!prev_rsp, "R4 single pulse", prev_rsp, 0);
                if (rdq.size() == 0) chk(0, "R4 unexpected read data", 1, 0);
                else begin
                    rd = rdq.pop_front();
                    chk((rsp_rdata & rd.mask) == rd.data, "R4 read data", rsp_rdata & rd.mask, rd.data);
                end
            end
            ras_low_run  = dram_ras_n ? 0 : ras_low_run + 1;
            ras_high_run = dram_ras_n ? ras_high_run + 1 : 0;
            cas_low_run  = cas_any ? cas_low_run + 1 : 0;
            cas_high_run = cas_any ? 0 : cas_high_run + 1;
            prev_ras = dram_ras_n;
            prev_cas = cas_any;
            prev_rsp = rsp_valid;
        end
    end

    task automatic do_req(input int addr, input bit wr, input logic [1:0] be, input logic [15:0] data);
        op_t op;
        rd_t rd;
        logic [1:0] l;
        logic [15:0] m;
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = 18'(addr); req_be = be; req_wdata = data;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        l = (be == 2'b00) ? 2'b11 : be;
        m = lmask(l);
        op.addr = addr; op.wr = wr; op.lanes = l; op.data = data;
        opq.push_back(op);
        if (wr) shadow[addr] = (rd_word(shadow, addr) & ~m) | (data & m);
        else begin
            rd.mask = m; rd.data = rd_word(shadow, addr) & m;
            rdq.push_back(rd);
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (opq.size() != 0 || rdq.size() != 0 || in_acc) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_ref();
        int c;
        c = ref_cnt;
        while (ref_cnt == c) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && (&dram_cas_n) && dram_we_n && dram_oe_n, "R12 reset strobes high",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 5'h1f);
        chk(!dram_dq_oe && !rsp_valid, "R12 reset bus and rsp", {dram_dq_oe, rsp_valid}, 0);
        chk(req_ready, "R12 ready after reset", req_ready, 1);
        mon_on = 1'b1;

        // word write and read back, then byte lanes on the same word
        do_req((5 << 9) | 3, 1, 2'b11, 16'hA55A);
        do_req((5 << 9) | 3, 0, 2'b11, 16'h0);
        do_req((5 << 9) | 3, 1, 2'b01, 16'h1234);
        do_req((5 << 9) | 3, 1, 2'b10, 16'hBEEF);
        do_req((5 << 9) | 3, 0, 2'b11, 16'h0);
        do_req((5 << 9) | 3, 0, 2'b01, 16'h0);
        do_req((5 << 9) | 3, 0, 2'b10, 16'h0);
        do_req((5 << 9) | 4, 1, 2'b00, 16'hC3C3);
        do_req((5 << 9) | 4, 0, 2'b00, 16'h0);
        drain();

        // page burst right after a refresh, then a row miss
        wait_ref();
        hit_log.delete();
        do_req((7 << 9) | 10, 1, 2'b11, 16'h7777);
        do_req((7 << 9) | 11, 1, 2'b11, 16'h8888);
        do_req((7 << 9) | 10, 0, 2'b11, 16'h0);
        do_req((9 << 9) | 10, 0, 2'b11, 16'h0);
        drain();
        chk(hit_log.size() == 4, "R5 access count", hit_log.size(), 4);
        if (hit_log.size() == 4) begin
            chk(hit_log[0] == 0, "R6 first access opens row", hit_log[0], 0);
            chk(hit_log[1] && hit_log[2], "R5 page hits", {hit_log[1], hit_log[2]}, 2'b11);
            chk(hit_log[3] == 0, "R6 row miss reopens", hit_log[3], 0);
        end

        // open row left idle must be closed by the guard
        do_req((2 << 9) | 1, 0, 2'b11, 16'h0);
        repeat (T_RAS_MAX * 3) @(negedge clk);
        chk(dram_ras_n, "R10 idle row closed", dram_ras_n, 1);

        // mixed traffic over a few rows so refresh lands on every phase
        for (int i = 0; i < 400; i++) begin
            int a;
            a = (($urandom % 3) << 9) | ($urandom % 8);
            do_req(a, 1'($urandom % 2), 2'($urandom % 4), 16'($urandom));
            if (($urandom % 16) == 0) repeat ($urandom % 50) @(negedge clk);
        end
        drain();
        wait_ref();
        chk(ref_cnt >= 3, "R8 refresh count", ref_cnt, 3);
        chk(opq.size() == 0 && rdq.size() == 0, "R4 all requests completed", opq.size() + rdq.size(), 0);
        chk(req_ready || !dram_ras_n || dram_cas_n != 2'b11, "R9 controller free after refresh", req_ready, 1);
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule